// File: doc/BRIEF.md
# Event Log Mission Controller

This block runs an event-logging mission for a single external event strobe that has already been filtered upstream. A mission is armed by software. The first event of the mission captures the current date and time word as a start stamp. Every later event stores the elapsed-time count since the previous event as a two-byte entry in a byte-wide log memory. The count is then restarted. An event counter tracks every event the block accepts.

The elapsed-time counter runs from either a one-second or a one-minute tick, as selected by `rate_min_i`. The log holds `N_ENT` two-byte entries. When the log is full, one of two things happens. If wrap is enabled, the block spills the running count into a separate "entry zero" register, re-stamps the time, wraps the write pointer and raises a sticky wrap flag. If wrap is disabled, the mission ends on the last entry.

A software-armed clear sweep writes zero to every log byte and resets the counts and the stamp. A mission may be armed only after such a clear has completed. Strobes must be at least three clock cycles apart, and register-write strobes must not share a cycle with an event.

Top module: `elc_mission_ctrl`

## Requirements
- R1: An event that arrives while `me_o`=1 and no start stamp has yet been taken does the following: it copies `tod_i` into `stamp_o`, sets `mip_o`, clears `mem_clr_o` and raises `ec_o` to 1. It performs no log write.
- R2: An event during a running mission with `ptr_o` < `N_ENT` stores the elapsed count in two steps. The low byte goes to byte address 2·`ptr_o` in the first cycle after the event edge. The high byte goes to address 2·`ptr_o`+1 in the following cycle. `ptr_o` then advances by one.
- R3: `ec_o` rises by exactly one on every accepted event: the first event, a logged event or a wrap event.
- R4: While a stamp is held, `etc_o` counts `sec_tick_i` pulses when `rate_min_i`=0 and `min_tick_i` pulses when `rate_min_i`=1. The tick that is not selected is ignored. Every accepted event records the value held before its edge and restarts the count at 0; a tick in the same cycle as the event is dropped.
- R5: An event with `ptr_o`=`N_ENT` and `roll_en_i`=1 does the following: it copies the elapsed count into `ev0_o`, re-latches `tod_i` into `stamp_o`, sets `ptr_o` to 0 and sets `rof_o`. It writes no log byte. After this, `ptr_o` names the oldest stored entry.
- R6: With `roll_en_i`=0, the event that fills the last entry ends the mission by clearing both `mip_o` and `me_o`. Later events change no output and cause no write.
- R7: While `mip_o`=1, writes of 0 to the mission-enable bit or to the mission-running bit have no effect.
- R8: A write of 1 to the enable bit (`me_wr_i` with `me_wdata_i`=1) is accepted only while `mem_clr_o`=1, and it clears `clr_en_o`. A write of 1 to the running bit (`mip_wr_i` with `mip_wdata_i`=1) has the same condition. It sets `mip_o`, sets `me_o` and clears `clr_en_o`.
- R9: A clear is started by `cm_wr_i` while `clr_en_o`=1, `mip_o`=0 and `me_o`=0. It then does the following:
  - It writes 0 to byte addresses 0 to 2·`N_ENT`−1, one byte per cycle starting in the cycle after the strobe edge.
  - It zeroes `ec_o`, `etc_o`, `ptr_o`, `ev0_o`, `stamp_o` and `rof_o` at the strobe edge.
  - It sets `mem_clr_o` at the edge that ends the sweep.
  With `clr_en_o`=0, the strobe has no effect.
- R10: After reset, every flag and count is 0 and no log write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Filtered event strobe, one cycle |
| sec_tick_i | input | 1 | One-second tick |
| min_tick_i | input | 1 | One-minute tick |
| rate_min_i | input | 1 | Elapsed-time rate: 0 seconds, 1 minutes |
| roll_en_i | input | 1 | Allow wrap when the log is full |
| tod_i | input | STAMP_W | Current date and time word |
| me_wr_i | input | 1 | Write strobe for the mission-enable bit |
| me_wdata_i | input | 1 | Value written to the mission-enable bit |
| mip_wr_i | input | 1 | Write strobe for the mission-running bit |
| mip_wdata_i | input | 1 | Value written to the mission-running bit |
| clren_wr_i | input | 1 | Write strobe for the clear-enable bit |
| clren_wdata_i | input | 1 | Value written to the clear-enable bit |
| cm_wr_i | input | 1 | Clear command strobe |
| me_o | output | 1 | Mission enable |
| mip_o | output | 1 | Mission running |
| clr_en_o | output | 1 | Clear enable |
| mem_clr_o | output | 1 | Log is freshly cleared |
| rof_o | output | 1 | Log has wrapped at least once |
| ec_o | output | EC_W | Event counter |
| etc_o | output | 16 | Elapsed-time counter |
| ptr_o | output | $clog2(N_ENT)+1 | Entry write pointer |
| ev0_o | output | 16 | Elapsed count spilled at wrap |
| stamp_o | output | STAMP_W | Start stamp |
| mem_we_o | output | 1 | Log byte write enable |
| mem_addr_o | output | $clog2(N_ENT)+1 | Log byte address |
| mem_wdata_o | output | 8 | Log byte data |

## Verification
A wrong internal state shows at the ports in the next cycle, because every output is a register or a selection between registers. For example:
- A stale started flag makes the next event re-stamp instead of log, or log instead of stamp. This shows on `stamp_o` and `mem_we_o` one cycle after the event edge.
- An off-by-one write pointer moves the log bytes to the wrong address at once. It also shifts the full point, so a wrap or a mission end comes one event early or late.
- A lost clear step shows as a missing address in the zero sweep, or as a `mem_clr_o` edge in the wrong cycle.

// File: rtl/elc_pkg.sv
package elc_pkg;
    localparam int ETC_W = 16;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_FIRST = 2'd1,
        EV_LOG   = 2'd2,
        EV_ROLL  = 2'd3
    } ev_kind_e;
endpackage

// File: rtl/elc_etc.sv
module elc_etc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         zero_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (zero_i)
            cnt_d = '0;
        else if (run_i && tick_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R4: the count only restarts or steps by one
    p_etc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/elc_clear.sv
module elc_clear #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic [AW-1:0] addr_o,
    output logic          done_o
);
    typedef struct packed {
        logic          busy;
        logic [AW-1:0] cnt;
    } sweep_t;

    sweep_t s_d, s_q;
    logic   last;

    assign last = s_q.busy && (s_q.cnt == {AW{1'b1}});

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            if (last) s_d.busy = 1'b0;
            else      s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign addr_o = s_q.cnt;
    assign done_o = last;

    // R9: the sweep visits consecutive addresses without a gap
    p_sweep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !last && !start_i) |=> (s_q.busy && s_q.cnt == $past(s_q.cnt) + 1'b1));
endmodule

// File: rtl/elc_wport.sv
module elc_wport #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          log_i,
    input  logic [AW-1:0] base_i,
    input  logic [15:0]   val_i,
    input  logic          clr_busy_i,
    input  logic [AW-1:0] clr_addr_i,
    output logic          busy_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    data_o
);
    typedef struct packed {
        logic          we;
        logic          pend;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    msb;
    } wr_t;

    wr_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        w_d.we   = 1'b0;
        w_d.pend = 1'b0;
        if (log_i) begin
            w_d.we   = 1'b1;
            w_d.pend = 1'b1;
            w_d.addr = base_i;
            w_d.data = val_i[7:0];
            w_d.msb  = val_i[15:8];
        end else if (w_q.pend) begin
            w_d.we   = 1'b1;
            w_d.addr = w_q.addr + 1'b1;
            w_d.data = w_q.msb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign busy_o = w_q.we;
    assign we_o   = clr_busy_i | w_q.we;
    assign addr_o = clr_busy_i ? clr_addr_i : w_q.addr;
    assign data_o = clr_busy_i ? 8'h00 : w_q.data;

    // R2: the high byte lands one address above the low byte, next cycle
    p_msb_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.pend |=> (we_o && addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/elc_mission_ctrl.sv
module elc_mission_ctrl
    import elc_pkg::*;
#(
    parameter int N_ENT   = 1024,
    parameter int STAMP_W = 64,
    parameter int EC_W    = 16,
    localparam int PW     = $clog2(N_ENT) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_i,
    input  logic               sec_tick_i,
    input  logic               min_tick_i,
    input  logic               rate_min_i,
    input  logic               roll_en_i,
    input  logic [STAMP_W-1:0] tod_i,
    input  logic               me_wr_i,
    input  logic               me_wdata_i,
    input  logic               mip_wr_i,
    input  logic               mip_wdata_i,
    input  logic               clren_wr_i,
    input  logic               clren_wdata_i,
    input  logic               cm_wr_i,
    output logic               me_o,
    output logic               mip_o,
    output logic               clr_en_o,
    output logic               mem_clr_o,
    output logic               rof_o,
    output logic [EC_W-1:0]    ec_o,
    output logic [ETC_W-1:0]   etc_o,
    output logic [PW-1:0]      ptr_o,
    output logic [ETC_W-1:0]   ev0_o,
    output logic [STAMP_W-1:0] stamp_o,
    output logic               mem_we_o,
    output logic [PW-1:0]      mem_addr_o,
    output logic [7:0]         mem_wdata_o
);
    localparam logic [PW-1:0] FULL_PTR = PW'(N_ENT);

    typedef struct packed {
        logic               me;
        logic               mip;
        logic               started;
        logic               clr_en;
        logic               mem_clr;
        logic               rof;
        logic [EC_W-1:0]    ec;
        logic [PW-1:0]      ptr;
        logic [ETC_W-1:0]   ev0;
        logic [STAMP_W-1:0] stamp;
    } ctl_t;

    ctl_t       c_d, c_q;
    ev_kind_e   kind;
    logic       clr_go, clr_busy, clr_done, wr_busy, full, tick_sel;
    logic [PW-1:0]    clr_addr;
    logic [ETC_W-1:0] etc_val;

    assign full     = (c_q.ptr == FULL_PTR);
    assign tick_sel = rate_min_i ? min_tick_i : sec_tick_i;

    always_comb begin
        c_d    = c_q;
        kind   = EV_NONE;
        clr_go = 1'b0;

        if (evt_i && !clr_busy) begin
            if (c_q.me && !c_q.started)
                kind = EV_FIRST;
            else if (c_q.mip && c_q.started) begin
                if (!full)          kind = EV_LOG;
                else if (roll_en_i) kind = EV_ROLL;
            end
        end

        case (kind)
            EV_FIRST: begin
                c_d.mip     = 1'b1;
                c_d.started = 1'b1;
                c_d.mem_clr = 1'b0;
                c_d.stamp   = tod_i;
                c_d.ec      = c_q.ec + 1'b1;
            end
            EV_LOG: begin
                c_d.ptr = c_q.ptr + 1'b1;
                c_d.ec  = c_q.ec + 1'b1;
                if ((c_q.ptr == FULL_PTR - 1'b1) && !roll_en_i) begin
                    c_d.me      = 1'b0;
                    c_d.mip     = 1'b0;
                    c_d.started = 1'b0;
                end
            end
            EV_ROLL: begin
                c_d.ev0   = etc_val;
                c_d.stamp = tod_i;
                c_d.ptr   = '0;
                c_d.rof   = 1'b1;
                c_d.ec    = c_q.ec + 1'b1;
            end
            default: ;
        endcase

        if (me_wr_i) begin
            if (me_wdata_i) begin
                if (c_q.mem_clr) begin
                    c_d.me     = 1'b1;
                    c_d.clr_en = 1'b0;
                end
            end else if (!c_q.mip) begin
                c_d.me = 1'b0;
            end
        end

        if (mip_wr_i && mip_wdata_i && c_q.mem_clr) begin
            c_d.mip    = 1'b1;
            c_d.me     = 1'b1;
            c_d.clr_en = 1'b0;
        end

        if (clren_wr_i)
            c_d.clr_en = clren_wdata_i;

        if (cm_wr_i && c_q.clr_en && !c_q.mip && !c_q.me && !clr_busy && !wr_busy) begin
            clr_go      = 1'b1;
            c_d.ec      = '0;
            c_d.ptr     = '0;
            c_d.rof     = 1'b0;
            c_d.ev0     = '0;
            c_d.stamp   = '0;
            c_d.started = 1'b0;
            c_d.mem_clr = 1'b0;
        end

        if (clr_done)
            c_d.mem_clr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    elc_etc #(.W(ETC_W)) etc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (c_q.started),
        .tick_i (tick_sel),
        .zero_i ((kind != EV_NONE) || clr_go),
        .cnt_o  (etc_val)
    );

    elc_clear #(.AW(PW)) clear_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (clr_go),
        .busy_o  (clr_busy),
        .addr_o  (clr_addr),
        .done_o  (clr_done)
    );

    elc_wport #(.AW(PW)) wport_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .log_i      (kind == EV_LOG),
        .base_i     ({c_q.ptr[PW-2:0], 1'b0}),
        .val_i      (etc_val),
        .clr_busy_i (clr_busy),
        .clr_addr_i (clr_addr),
        .busy_o     (wr_busy),
        .we_o       (mem_we_o),
        .addr_o     (mem_addr_o),
        .data_o     (mem_wdata_o)
    );

    assign me_o      = c_q.me;
    assign mip_o     = c_q.mip;
    assign clr_en_o  = c_q.clr_en;
    assign mem_clr_o = c_q.mem_clr;
    assign rof_o     = c_q.rof;
    assign ec_o      = c_q.ec;
    assign etc_o     = etc_val;
    assign ptr_o     = c_q.ptr;
    assign ev0_o     = c_q.ev0;
    assign stamp_o   = c_q.stamp;

    // R3: the event count only steps by one or is cleared
    p_ec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ec != $past(c_q.ec)) |-> (c_q.ec == '0 || c_q.ec == $past(c_q.ec) + 1'b1));

    // R5: the wrap flag rises together with the pointer returning to zero
    p_rof_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.rof) |-> (c_q.ptr == '0));

    // R6: a mission only ends with the log filled
    p_end_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.mip) |-> (c_q.ptr == FULL_PTR));

    // R7: a running mission survives unless its last entry is being written
    p_mip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.mip && c_q.ptr != FULL_PTR - 1'b1) |=> c_q.mip);

    // R8: enable rises only out of a cleared log
    p_me_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.me) |-> $past(c_q.mem_clr));
endmodule

// File: tb/elc_mission_ctrl_tb_top.sv
`timescale 1ns/1ps
module elc_mission_ctrl_tb_top;
    localparam int NE = 8;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt = 0, stk = 0, mtk = 0, rmin = 0, roll = 0;
    logic [63:0] tod = 64'h0;
    logic me_wr = 0, me_wd = 0, mip_wr = 0, mip_wd = 0, ce_wr = 0, ce_wd = 0, cm = 0;

    logic me, mip, clr_en, mem_clr, rof, we;
    logic [15:0] ec, etc, ev0;
    logic [PW-1:0] ptr, addr;
    logic [7:0] wdata;
    logic [63:0] stamp;

    always #2 clk = ~clk;

    elc_mission_ctrl #(.N_ENT(NE), .STAMP_W(64), .EC_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sec_tick_i(stk), .min_tick_i(mtk),
        .rate_min_i(rmin), .roll_en_i(roll), .tod_i(tod),
        .me_wr_i(me_wr), .me_wdata_i(me_wd), .mip_wr_i(mip_wr), .mip_wdata_i(mip_wd),
        .clren_wr_i(ce_wr), .clren_wdata_i(ce_wd), .cm_wr_i(cm),
        .me_o(me), .mip_o(mip), .clr_en_o(clr_en), .mem_clr_o(mem_clr), .rof_o(rof),
        .ec_o(ec), .etc_o(etc), .ptr_o(ptr), .ev0_o(ev0), .stamp_o(stamp),
        .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R10";
    bit done = 0, armed = 0;

    // reference model state
    bit m_me, m_mip, m_started, m_clr_en, m_mem_clr, m_rof, m_clearing;
    int m_ec, m_etc, m_ptr, m_ev0, m_clr_cnt;
    logic [63:0] m_stamp;
    int wq[$];
    bit exp_we;
    int exp_addr, exp_data;

    logic [7:0] bmem [0:2*NE-1];
    int wr_count = 0;

    always @(posedge clk) begin : model
        int kind, old_etc, e;
        bit busy, tk, p_mem_clr, p_mip, p_me, p_clr_en;
        armed <= 1'b1;
        if (!rst_n) begin
            m_me = 0; m_mip = 0; m_started = 0; m_clr_en = 0; m_mem_clr = 0; m_rof = 0;
            m_clearing = 0; m_ec = 0; m_etc = 0; m_ptr = 0; m_ev0 = 0; m_clr_cnt = 0;
            m_stamp = 0; wq.delete(); exp_we = 0; exp_addr = 0; exp_data = 0;
        end else begin
            p_mem_clr = m_mem_clr; p_mip = m_mip; p_me = m_me; p_clr_en = m_clr_en;
            busy = m_clearing;
            if (m_clearing) begin
                m_clr_cnt--;
                if (m_clr_cnt == 0) begin m_clearing = 0; m_mem_clr = 1; end
            end
            kind = 0;
            if (evt && !busy) begin
                if (m_me && !m_started) kind = 1;
                else if (m_mip && m_started) begin
                    if (m_ptr < NE) kind = 2;
                    else if (roll) kind = 3;
                end
            end
            tk = rmin ? mtk : stk;
            old_etc = m_etc;
            if (kind != 0) m_etc = 0;
            else if (m_started && tk) m_etc = (m_etc + 1) % 65536;
            case (kind)
                1: begin m_mip = 1; m_started = 1; m_mem_clr = 0; m_stamp = tod; m_ec++; end
                2: begin
                    wq.push_back((2*m_ptr) * 256 + (old_etc % 256));
                    wq.push_back((2*m_ptr + 1) * 256 + (old_etc / 256));
                    if (m_ptr == NE-1 && !roll) begin m_me = 0; m_mip = 0; m_started = 0; end
                    m_ptr++; m_ec++;
                end
                3: begin m_ev0 = old_etc; m_stamp = tod; m_ptr = 0; m_rof = 1; m_ec++; end
                default: ;
            endcase
            if (me_wr) begin
                if (me_wd) begin
                    if (p_mem_clr) begin m_me = 1; m_clr_en = 0; end
                end else if (!p_mip) m_me = 0;
            end
            if (mip_wr && mip_wd && p_mem_clr) begin m_mip = 1; m_me = 1; m_clr_en = 0; end
            if (ce_wr) m_clr_en = ce_wd;
            if (cm && p_clr_en && !p_mip && !p_me && !busy && !exp_we) begin
                m_ec = 0; m_ptr = 0; m_rof = 0; m_ev0 = 0; m_stamp = 0; m_started = 0;
                m_mem_clr = 0; m_etc = 0; m_clearing = 1; m_clr_cnt = 2*NE;
                for (int i = 0; i < 2*NE; i++) wq.push_back(i * 256);
            end
            if (wq.size() > 0) begin
                e = wq.pop_front();
                exp_we = 1; exp_addr = e / 256; exp_data = e % 256;
            end else exp_we = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && armed && !done) begin
            logic [134:0] act_v, exp_v;
            bit bad;
            act_v = {me, mip, clr_en, mem_clr, rof, ec, etc, 3'b0, ptr, ev0, stamp};
            exp_v = {m_me, m_mip, m_clr_en, m_mem_clr, m_rof, m_ec[15:0], m_etc[15:0],
                     7'(m_ptr), m_ev0[15:0], m_stamp};
            bad = (act_v !== exp_v) || (we !== exp_we) ||
                  (exp_we && (addr !== PW'(exp_addr) || wdata !== 8'(exp_data)));
            n_chk++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s cycle compare: act=%h we=%b a=%0d d=%h exp=%h we=%b a=%0d d=%h",
                         cur_req, act_v, we, addr, wdata, exp_v, exp_we, exp_addr, exp_data);
            end
            if (we === 1'b1) begin bmem[addr] = wdata; wr_count++; end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_evt();
        @(posedge clk); #1 evt = 1;
        @(posedge clk); #1 evt = 0;
        cyc(2);
    endtask

    task automatic ticks(int n, bit minute);
        repeat (n) begin
            @(posedge clk); #1 if (minute) mtk = 1; else stk = 1;
            @(posedge clk); #1 mtk = 0; stk = 0;
        end
    endtask

    task automatic wr_me(bit v);
        @(posedge clk); #1 me_wr = 1; me_wd = v;
        @(posedge clk); #1 me_wr = 0;
    endtask

    task automatic wr_mip(bit v);
        @(posedge clk); #1 mip_wr = 1; mip_wd = v;
        @(posedge clk); #1 mip_wr = 0;
    endtask

    task automatic do_clear();
        @(posedge clk); #1 ce_wr = 1; ce_wd = 1;
        @(posedge clk); #1 ce_wr = 0; cm = 1;
        @(posedge clk); #1 cm = 0;
        cyc(2*NE + 2);
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 0;
        cyc(2);
        rst_n = 1;
        cyc(1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int wc;
        cyc(3);
        rst_n = 1;
        cyc(1);
        cur_req = "R10";
        chk("R10 reset flags", {me, mip, clr_en, mem_clr, rof, we}, 0);
        chk("R10 reset counts", {ec, etc, ev0, 12'(ptr)}, 0);

        cur_req = "R8";
        wr_me(1);
        chk("R8 enable refused before clear", me, 0);

        cur_req = "R9";
        @(posedge clk); #1 cm = 1;
        @(posedge clk); #1 cm = 0;
        cyc(3);
        chk("R9 clear ignored without enable", {mem_clr, we}, 0);
        do_clear();
        chk("R9 clear completed", {mem_clr, 16'(ec), 12'(ptr)}, {1'b1, 28'h0});
        wc = 0;
        for (int i = 0; i < 2*NE; i++) if (bmem[i] === 8'h00) wc++;
        chk("R9 all bytes zeroed", wc, 2*NE);

        cur_req = "R8";
        wr_me(1);
        chk("R8 enable accepted, clear-enable dropped", {me, clr_en, mip}, 3'b100);

        cur_req = "R1";
        roll = 1;
        tod = 64'h2024_0612_1530_4501;
        wc = wr_count;
        pulse_evt();
        chk("R1 start stamp", stamp, 64'h2024_0612_1530_4501);
        chk("R1 running and counted", {mip, 16'(ec)}, {1'b1, 16'd1});
        chk("R1 no log write", wr_count, wc);

        cur_req = "R7";
        wr_me(0);
        wr_mip(0);
        chk("R7 zero writes ignored", {me, mip}, 2'b11);

        cur_req = "R2";
        ticks(3, 0);
        pulse_evt();
        chk("R2 entry0 bytes", {bmem[0], bmem[1]}, 16'h0300);
        chk("R2 pointer advance", ptr, 1);

        cur_req = "R4";
        rmin = 1;
        ticks(2, 0);
        ticks(5, 1);
        pulse_evt();
        chk("R4 minute rate entry1", {bmem[3], bmem[2]}, 16'd5);
        rmin = 0;
        ticks(300, 0);
        pulse_evt();
        chk("R2 entry2 high and low byte", {bmem[5], bmem[4]}, 16'd300);
        ticks(1, 0);
        @(posedge clk); #1 stk = 1; evt = 1;
        @(posedge clk); #1 stk = 0; evt = 0;
        cyc(2);
        chk("R4 same-cycle tick dropped", {bmem[7], bmem[6]}, 16'd1);
        chk("R4 restarted at zero", etc, 0);

        for (int k = 4; k < NE; k++) begin
            ticks(k, 0);
            pulse_evt();
        end
        cur_req = "R3";
        chk("R3 event count at full", ec, 9);
        chk("R3 pointer at full", ptr, NE);

        cur_req = "R5";
        tod = 64'h2024_0613_0000_0007;
        wc = wr_count;
        ticks(2, 0);
        pulse_evt();
        chk("R5 spill register", ev0, 2);
        chk("R5 wrap pointer and flag", {rof, 12'(ptr)}, {1'b1, 12'd0});
        chk("R5 stamp relatched", stamp, 64'h2024_0613_0000_0007);
        chk("R5 no write on wrap", wr_count, wc);
        ticks(6, 0);
        pulse_evt();
        chk("R5 overwrite oldest", {bmem[1], bmem[0]}, 16'd6);
        chk("R3 count after wrap", ec, 11);

        cur_req = "R8";
        do_reset();
        do_clear();
        roll = 0;
        wr_mip(1);
        chk("R8 running-bit start sets enable", {mip, me, clr_en}, 3'b110);

        cur_req = "R6";
        pulse_evt();
        for (int k = 0; k < NE; k++) begin
            ticks(1, 0);
            pulse_evt();
        end
        chk("R6 mission ended", {mip, me, 12'(ptr)}, {2'b00, 12'(NE)});
        wc = wr_count;
        ticks(2, 0);
        pulse_evt();
        chk("R6 late event ignored", {16'(ec), 12'(ptr)}, {16'd9, 12'(NE)});
        chk("R6 no write after end", wr_count, wc);
        cur_req = "R8";
        wr_me(1);
        chk("R8 enable refused on used log", me, 0);

        cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule